// File: doc/BRIEF.md
# 32-bit Integer Logic ALU

This unit is the integer logic and simple arithmetic execution slot of a small RISC core. Each operation carries a 5-bit operation code, two 32-bit register operands (A and B) and a 16-bit immediate. The unit returns a 32-bit result together with a flag that marks operation codes it does not implement. The operation set covers register and immediate addition, a full two-operand logic set that includes complemented-operand forms, immediate logic forms in low-half and upper-half variants, negation, byte and halfword sign extension, register move and load-immediate. Addition wraps modulo 2^32. No carry, overflow or condition information is produced.

Operations enter on a valid/ready stream and leave one clock later on a second valid/ready stream through a single output register. The upstream side sees `in_ready` high whenever the output register is empty or is being drained in the same cycle. An operation is taken when `in_valid` and `in_ready` are both high at a rising clock edge. Downstream back-pressure (`out_ready` low) holds the current result and flag unchanged on the output, and drops `in_ready` until the result is taken. A held `in_valid` with `in_ready` low is not consumed, and its inputs may change freely.

Top module: `alu32_exec`

## Requirements
- R1: ADD (code 0) returns A+B. ADDI (code 1) returns A plus the immediate sign-extended from bit 15. Both wrap modulo 2^32.
- R2: The upper-half immediate forms place the immediate in bits 31..16 with zeros in bits 15..0. ADDIS (code 2) adds that value to A. ANDIS (12), ORIS (14) and XORIS (16) combine it with A by AND, OR and XOR.
- R3: The register logic codes return: AND (3) A&B, ANDC (4) A&~B, NAND (5) ~(A&B), NOR (6) ~(A|B), NOT (7) ~A, OR (8) A|B, ORC (9) A|~B, XOR (10) A^B.
- R4: ANDI (11), ORI (13) and XORI (15) zero-extend the immediate to 32 bits and combine it with A by AND, OR and XOR.
- R5: NEG (17) returns the two's complement ~A+1. Zero maps to zero, and 0x80000000 maps to itself.
- R6: EXTB (18) copies A bit 7 into bits 31..8 above A[7:0]. EXTH (19) copies A bit 15 into bits 31..16 above A[15:0].
- R7: MOVE (20) returns B unchanged. LI (21) returns the immediate sign-extended from bit 15.
- R8: Codes 22 to 31 return a zero result with `out_illegal` high. Every code 0 to 21 returns `out_illegal` low.
- R9: A transfer accepted at an edge appears on `out_result`/`out_illegal` with `out_valid` high after that same edge.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and flag stay stable, and inputs offered meanwhile are not accepted.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers an operation |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_imm | input | 16 | Immediate |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_result | output | 32 | Result |
| out_illegal | output | 1 | Operation code was not recognised |

## Verification
The assertions assume that upstream keeps `in_op`, `in_a`, `in_b` and `in_imm` at known values whenever `in_valid` is high. They also assume that `out_ready` is driven to a known level after reset. The function checks compare the registered result against the inputs of the previous accepted transfer. For this reason they rely on the upstream holding those inputs steady across the accepting edge. The bench changes every input only on the falling clock edge and never leaves an input undriven. The back-pressure test deliberately changes the offered operation while `in_ready` is low, to show it is not taken.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDI  = 5'd1,
    OP_ADDIS = 5'd2,
    OP_AND   = 5'd3,
    OP_ANDC  = 5'd4,
    OP_NAND  = 5'd5,
    OP_NOR   = 5'd6,
    OP_NOT   = 5'd7,
    OP_OR    = 5'd8,
    OP_ORC   = 5'd9,
    OP_XOR   = 5'd10,
    OP_ANDI  = 5'd11,
    OP_ANDIS = 5'd12,
    OP_ORI   = 5'd13,
    OP_ORIS  = 5'd14,
    OP_XORI  = 5'd15,
    OP_XORIS = 5'd16,
    OP_NEG   = 5'd17,
    OP_EXTB  = 5'd18,
    OP_EXTH  = 5'd19,
    OP_MOVE  = 5'd20,
    OP_LI    = 5'd21
  } alu_op_e;
endpackage

// File: rtl/alu32_imm_ext.sv
module alu32_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] imm_sext,
  output logic [DATA_W-1:0] imm_zext,
  output logic [DATA_W-1:0] imm_upper
);
  localparam int FILL_W = DATA_W - IMM_W;
  localparam int LOW_W  = DATA_W - IMM_W;

  assign imm_sext  = {{FILL_W{imm[IMM_W-1]}}, imm};
  assign imm_zext  = {{FILL_W{1'b0}}, imm};
  assign imm_upper = {imm, {LOW_W{1'b0}}};
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm_zext,
  input  logic [DATA_W-1:0] imm_upper,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  always_comb begin
    hit = 1'b1;
    res = '0;
    unique case (op)
      OP_AND:   res = opa & opb;
      OP_ANDC:  res = opa & ~opb;
      OP_NAND:  res = ~(opa & opb);
      OP_NOR:   res = ~(opa | opb);
      OP_NOT:   res = ~opa;
      OP_OR:    res = opa | opb;
      OP_ORC:   res = opa | ~opb;
      OP_XOR:   res = opa ^ opb;
      OP_ANDI:  res = opa & imm_zext;
      OP_ANDIS: res = opa & imm_upper;
      OP_ORI:   res = opa | imm_zext;
      OP_ORIS:  res = opa | imm_upper;
      OP_XORI:  res = opa ^ imm_zext;
      OP_XORIS: res = opa ^ imm_upper;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu32_arith.sv
module alu32_arith
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm_sext,
  input  logic [DATA_W-1:0] imm_upper,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  localparam int BYTE_FILL = DATA_W - 8;
  localparam int HALF_FILL = DATA_W - 16;

  logic [DATA_W-1:0] addend;
  logic              use_adder;

  // one shared adder for the three add forms
  always_comb begin
    use_adder = 1'b1;
    unique case (op)
      OP_ADD:   addend = opb;
      OP_ADDI:  addend = imm_sext;
      OP_ADDIS: addend = imm_upper;
      default: begin
        addend    = '0;
        use_adder = 1'b0;
      end
    endcase
  end

  always_comb begin
    hit = 1'b1;
    res = '0;
    if (use_adder) begin
      res = opa + addend;
    end else begin
      unique case (op)
        OP_NEG:  res = ~opa + {{(DATA_W-1){1'b0}}, 1'b1};
        OP_EXTB: res = {{BYTE_FILL{opa[7]}}, opa[7:0]};
        OP_EXTH: res = {{HALF_FILL{opa[15]}}, opa[15:0]};
        OP_MOVE: res = opb;
        OP_LI:   res = imm_sext;
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu32_exec.sv
module alu32_exec
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
  logic [DATA_W-1:0] log_res, ari_res, nxt_res;
  logic              log_hit, ari_hit, nxt_ill;
  logic              accept;

  assign op = alu_op_e'(in_op);

  alu32_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) imm_i (
    .imm(in_imm), .imm_sext(imm_sext), .imm_zext(imm_zext), .imm_upper(imm_upper)
  );

  alu32_logic #(.DATA_W(DATA_W)) logic_i (
    .op(op), .opa(in_a), .opb(in_b), .imm_zext(imm_zext), .imm_upper(imm_upper),
    .res(log_res), .hit(log_hit)
  );

  alu32_arith #(.DATA_W(DATA_W)) arith_i (
    .op(op), .opa(in_a), .opb(in_b), .imm_sext(imm_sext), .imm_upper(imm_upper),
    .res(ari_res), .hit(ari_hit)
  );

  assign nxt_ill = !(log_hit || ari_hit);
  assign nxt_res = log_hit ? log_res : (ari_hit ? ari_res : '0);

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nxt_res;
      out_illegal <= nxt_ill;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  // R3
  andc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_ANDC) |=> (out_result == ($past(in_a) & ~$past(in_b))));

  // R5
  neg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_NEG) |=> (out_result + $past(in_a) == '0));

  // R7
  move_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_MOVE) |=> (out_result == $past(in_b)));

  // R2
  upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == OP_ORIS || in_op == OP_XORIS))
      |=> (out_result[HALF_W-1:0] == $past(in_a[HALF_W-1:0])));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/alu32_exec_tb_top.sv
module alu32_exec_tb_top;
  localparam int NV = 31;
  localparam int VW = 5 + 32 + 32 + 16 + 32 + 1;

  // {op, a, b, imm, expected result, expected illegal}
  localparam logic [VW-1:0] VECS [NV] = '{
    {5'd0,  32'h0000_0005, 32'h0000_0007, 16'h0000, 32'h0000_000C, 1'b0}, // R1
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0002, 16'h0000, 32'h0000_0001, 1'b0}, // R1 wrap
    {5'd1,  32'h0000_0100, 32'h0,         16'hFFFF, 32'h0000_00FF, 1'b0}, // R1 neg imm
    {5'd1,  32'h0000_0010, 32'h0,         16'h7FFF, 32'h0000_800F, 1'b0}, // R1
    {5'd2,  32'h0000_1234, 32'h0,         16'h8001, 32'h8001_1234, 1'b0}, // R2
    {5'd3,  32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 32'hF000_F000, 1'b0}, // R3
    {5'd4,  32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 32'h00F0_00F0, 1'b0}, // R3
    {5'd5,  32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 32'h0FFF_0FFF, 1'b0}, // R3
    {5'd6,  32'hF0F0_F0F0, 32'h0F00_0000, 16'h0000, 32'h000F_0F0F, 1'b0}, // R3
    {5'd7,  32'h1234_5678, 32'h0,         16'h0000, 32'hEDCB_A987, 1'b0}, // R3
    {5'd8,  32'h1200_0000, 32'h0034_0000, 16'h0000, 32'h1234_0000, 1'b0}, // R3
    {5'd9,  32'h0000_000F, 32'hFFFF_FF00, 16'h0000, 32'h0000_00FF, 1'b0}, // R3
    {5'd10, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0000, 32'h5555_AAAA, 1'b0}, // R3
    {5'd11, 32'hFFFF_FFFF, 32'h0,         16'h8421, 32'h0000_8421, 1'b0}, // R4
    {5'd12, 32'hFFFF_FFFF, 32'h0,         16'h8421, 32'h8421_0000, 1'b0}, // R2
    {5'd13, 32'h1000_0000, 32'h0,         16'h8000, 32'h1000_8000, 1'b0}, // R4
    {5'd14, 32'h0000_00FF, 32'h0,         16'hABCD, 32'hABCD_00FF, 1'b0}, // R2
    {5'd15, 32'hFFFF_FFFF, 32'h0,         16'h00FF, 32'hFFFF_FF00, 1'b0}, // R4
    {5'd16, 32'hFFFF_FFFF, 32'h0,         16'h00FF, 32'hFF00_FFFF, 1'b0}, // R2
    {5'd17, 32'h0000_0001, 32'h0,         16'h0000, 32'hFFFF_FFFF, 1'b0}, // R5
    {5'd17, 32'h0000_0000, 32'h0,         16'h0000, 32'h0000_0000, 1'b0}, // R5
    {5'd17, 32'h8000_0000, 32'h0,         16'h0000, 32'h8000_0000, 1'b0}, // R5
    {5'd18, 32'h1234_5680, 32'h0,         16'h0000, 32'hFFFF_FF80, 1'b0}, // R6
    {5'd18, 32'hFFFF_FF7F, 32'h0,         16'h0000, 32'h0000_007F, 1'b0}, // R6
    {5'd19, 32'h0000_8000, 32'h0,         16'h0000, 32'hFFFF_8000, 1'b0}, // R6
    {5'd19, 32'hABCD_7FFF, 32'h0,         16'h0000, 32'h0000_7FFF, 1'b0}, // R6
    {5'd20, 32'h0000_1111, 32'hDEAD_BEEF, 16'h0000, 32'hDEAD_BEEF, 1'b0}, // R7
    {5'd21, 32'h0000_1234, 32'h0,         16'hFFFE, 32'hFFFF_FFFE, 1'b0}, // R7
    {5'd21, 32'h0000_1234, 32'h0,         16'h7FFE, 32'h0000_7FFE, 1'b0}, // R7
    {5'd22, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000, 1'b1}, // R8
    {5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000, 1'b1}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  alu32_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    in_op  = v[VW-1 -: 5];
    in_a   = v[VW-6 -: 32];
    in_b   = v[VW-38 -: 32];
    in_imm = v[VW-70 -: 16];
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // table walk, one operation per cycle, R9 timing
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 out_valid", {31'd0, out_valid}, 32'd1);
      check($sformatf("R1-op vector %0d result", i), out_result, VECS[i][32:1]);
      check($sformatf("R8 vector %0d illegal", i), {31'd0, out_illegal}, {31'd0, VECS[i][0]});
    end

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[26]);          // MOVE -> DEAD_BEEF
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    drive(VECS[9]);           // NOT offered while stalled
    repeat (3) @(negedge clk);
    check("R10 held valid", {31'd0, out_valid}, 32'd1);
    check("R10 held result", out_result, 32'hDEAD_BEEF);
    check("R10 in_ready follows out_ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1;
    check("R10 in_ready with drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next result after drain", out_result, 32'hEDCB_A987);
    @(negedge clk);
    check("R10 valid drops after take", {31'd0, out_valid}, 32'd0);

    // R11 reset in mid-stream
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 valid cleared", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule